// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory instruction into a stream of per-element memory requests, at most one element per clock. A single-cycle start pulse captures the base address, the element width, the addressing mode, a signed byte stride, the vector length and the load/store and signed/unsigned attributes. On every cycle that is not stalled, the generator then consumes one element. For that element it presents a byte address, the element number and the byte lanes that the element covers inside the aligned 64-bit word.

Three addressing modes are supported. Sequential mode packs elements back to back. Strided mode steps by a signed byte distance. Gather/scatter mode adds a signed per-element offset, streamed in on `idxIn`, to the base. When masking is enabled, an element whose `maskBit` is low is consumed without a request. An element whose address is not a multiple of its size is also consumed without a request, and it raises `misalign` instead. The cycle after the last element carries a one-cycle `done` pulse. The memory, the data alignment and extension, and the switch network are outside this block.

Top module: `vec_addr_gen`

## Requirements
- R1: With `modeSel`=0 (sequential), element e has address base + e·S, where S is the element size in bytes.
- R2: With `modeSel`=1 (strided), element e has address base + e·stride. The stride is a signed byte count taken modulo 2^ADDR_W.
- R3: With `modeSel`=2 (gather/scatter), the address of the element being consumed is base + the sign-extended `idxIn` sampled in that same cycle.
- R4: The `widthSel` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 byte elements. For a requested element, bit i of `reqByteEn` (byte lane i) is set exactly for lanes addr[2:0] through addr[2:0]+S-1.
- R5: When masking is enabled and `maskBit` is 0, the current element is consumed with no request and no `misalign`.
- R6: An enabled element whose address is not a multiple of S raises `misalign` for that cycle instead of `reqValid`, and it is consumed.
- R7: While `stall` is high, no request or misalign is raised, and the element number and address do not advance.
- R8: `done` is high for exactly one cycle, the cycle after the last element is consumed, whether that element was requested, masked or misaligned.
- R9: A start with `vecLen`=0 gives `done` in the next cycle and no requests.
- R10: `reqStore` follows the captured direction. `reqSigned` is the captured signed flag for loads and 0 for stores.
- R11: A start pulse is ignored while a vector is in progress.
- R12: After reset, `busy`, `done`, `reqValid` and `misalign` are low.
- R13: Vector lengths up to MAX_VL (default 256) are supported, and `reqElem` numbers the elements 0 through length-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; configuration captured when idle |
| baseAddr | input | ADDR_W | Base byte address |
| modeSel | input | 2 | 0 sequential, 1 strided, 2 gather/scatter (3 acts as 0) |
| widthSel | input | 2 | Element size code: 0/1/2/3 = 8/16/32/64 bits |
| stride | input | ADDR_W | Signed byte stride for strided mode |
| vecLen | input | LEN_W | Number of elements, 0..MAX_VL |
| maskEn | input | 1 | Enables per-element masking |
| isStore | input | 1 | 1 store, 0 load |
| isSigned | input | 1 | Load elements to be sign-extended later |
| stall | input | 1 | Freezes element consumption |
| maskBit | input | 1 | Enable bit of the current element |
| idxIn | input | IDX_W | Signed byte offset of the current element |
| reqValid | output | 1 | Memory request for the current element |
| reqAddr | output | ADDR_W | Byte address of the current element |
| reqByteEn | output | 8 | Byte lanes within the aligned 64-bit word |
| reqElem | output | ELEM_W | Current element number |
| reqStore | output | 1 | Request direction |
| reqSigned | output | 1 | Signed-load marker |
| misalign | output | 1 | Current element is misaligned and skipped |
| busy | output | 1 | A vector is being processed |
| done | output | 1 | One-cycle completion pulse |

## Verification
Sequential runs at 32-bit and at 8-bit width with the full 256-element length separate the size-based step and the lane decode from the other modes. The long run also masks every third element and stalls periodically, which shows that masked and stalled cycles differ: a masked cycle consumes its element, a stalled one does not. A 64-bit run with a negative stride checks signed stepping and wrap. A 32-bit run with a 6-byte stride mixes aligned and misaligned elements, showing that misalignment skips an element without stopping the stream. A 16-bit gather with negative and odd offsets shows that each address is taken from the offset sampled in that cycle. A zero-length start and a start pulse during a run cover the completion and ignore rules.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    MODE_SEQ    = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2
  } modeE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new configuration
    logic step;     // advance to the next element
  } dpCtlT;

  function automatic logic [3:0] sizeBytes(input logic [1:0] w);
    return 4'(4'd1 << w);
  endfunction

endpackage

// File: rtl/vag_dp.sv
module vag_dp
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] strideIn,
  input  logic [1:0]        widthIn,
  input  logic [1:0]        modeIn,
  input  logic [IDX_W-1:0]  idxIn,
  output logic [ADDR_W-1:0] elemAddr,
  output logic [7:0]        byteEn,
  output logic              aligned
);

  logic [ADDR_W-1:0] baseQ, curQ, stepQ;
  logic [1:0]        widthQ;
  logic              indexQ;
  logic [ADDR_W-1:0] idxExt;
  logic [3:0]        sizeB;
  logic [15:0]       laneMask;
  logic [2:0]        lowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      curQ   <= '0;
      stepQ  <= '0;
      widthQ <= '0;
      indexQ <= 1'b0;
    end else if (ctl.capture) begin
      baseQ  <= baseIn;
      curQ   <= baseIn;
      widthQ <= widthIn;
      indexQ <= (modeIn == MODE_INDEX);
      stepQ  <= (modeIn == MODE_STRIDE) ? strideIn : ADDR_W'(sizeBytes(widthIn));
    end else if (ctl.step) begin
      curQ <= curQ + stepQ;
    end
  end

  assign idxExt   = ADDR_W'($signed(idxIn));
  assign elemAddr = indexQ ? (baseQ + idxExt) : curQ;
  assign sizeB    = sizeBytes(widthQ);
  assign lowMask  = 3'(sizeB - 4'd1);
  assign aligned  = (elemAddr[2:0] & lowMask) == 3'd0;
  assign laneMask = (16'd1 << sizeB) - 16'd1;
  assign byteEn   = laneMask[7:0] << elemAddr[2:0];

endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int LEN_W  = 9,
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic              maskEn,
  input  logic              isStore,
  input  logic              isSigned,
  input  logic              stall,
  input  logic              maskBit,
  input  logic              aligned,
  output dpCtlT             ctl,
  output logic              reqValid,
  output logic              misalign,
  output logic [ELEM_W-1:0] reqElem,
  output logic              reqStore,
  output logic              reqSigned,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} stateE;

  stateE            stateQ;
  logic [LEN_W-1:0] lenQ, cntQ;
  logic             maskQ, storeQ, signQ;
  logic             take, active, lastElem;

  assign take     = (stateQ == ST_RUN) && !stall;
  assign active   = !maskQ || maskBit;
  assign lastElem = cntQ == (lenQ - LEN_W'(1));

  assign ctl.capture = (stateQ == ST_IDLE) && start;
  assign ctl.step    = take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      lenQ   <= '0;
      cntQ   <= '0;
      maskQ  <= 1'b0;
      storeQ <= 1'b0;
      signQ  <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          lenQ   <= vecLen;
          cntQ   <= '0;
          maskQ  <= maskEn;
          storeQ <= isStore;
          signQ  <= isSigned;
          stateQ <= (vecLen == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (take) begin
          cntQ <= cntQ + LEN_W'(1);
          if (lastElem) stateQ <= ST_FIN;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqValid  = take && active && aligned;
  assign misalign  = take && active && !aligned;
  assign reqElem   = cntQ[ELEM_W-1:0];
  assign reqStore  = storeQ;
  assign reqSigned = signQ && !storeQ;
  assign busy      = (stateQ == ST_RUN);
  assign done      = (stateQ == ST_FIN);

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32,
  parameter int MAX_VL = 256,
  localparam int LEN_W  = $clog2(MAX_VL + 1),
  localparam int ELEM_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        widthSel,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic              maskEn,
  input  logic              isStore,
  input  logic              isSigned,
  input  logic              stall,
  input  logic              maskBit,
  input  logic [IDX_W-1:0]  idxIn,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqByteEn,
  output logic [ELEM_W-1:0] reqElem,
  output logic              reqStore,
  output logic              reqSigned,
  output logic              misalign,
  output logic              busy,
  output logic              done
);

  dpCtlT ctl;
  logic  aligned;

  vag_ctrl #(.LEN_W(LEN_W), .ELEM_W(ELEM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .maskEn(maskEn), .isStore(isStore), .isSigned(isSigned),
    .stall(stall), .maskBit(maskBit), .aligned(aligned), .ctl(ctl),
    .reqValid(reqValid), .misalign(misalign), .reqElem(reqElem),
    .reqStore(reqStore), .reqSigned(reqSigned), .busy(busy), .done(done)
  );

  vag_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseIn(baseAddr),
    .strideIn(stride), .widthIn(widthSel), .modeIn(modeSel),
    .idxIn(idxIn), .elemAddr(reqAddr), .byteEn(reqByteEn),
    .aligned(aligned)
  );

endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 9,
  parameter int ELEM_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [LEN_W-1:0]  vecLen,
  input logic              stall,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [7:0]        reqByteEn,
  input logic [ELEM_W-1:0] reqElem,
  input logic              misalign,
  input logic              busy,
  input logic              done
);

  // R6
  req_or_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && misalign));

  // R4
  first_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqByteEn[reqAddr[2:0]]);

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !reqValid && !misalign);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && stall |=> reqElem == $past(reqElem));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !done && start && vecLen == '0 |=> done && !busy);

  // R11
  run_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> busy || done);

endmodule

bind vec_addr_gen vag_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ELEM_W(ELEM_W)) u_chk (.*);

// File: tb/sim_vec_addr_gen.sv
`timescale 1ns/1ps
module sim_vec_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [1:0]  modeSel = '0;
  logic [1:0]  widthSel = '0;
  logic [31:0] stride = '0;
  logic [8:0]  vecLen = '0;
  logic        maskEn = 1'b0;
  logic        isStore = 1'b0;
  logic        isSigned = 1'b0;
  logic        stall = 1'b0;
  logic        maskBit = 1'b1;
  logic [31:0] idxIn = '0;
  logic        reqValid, reqStore, reqSigned, misalign, busy, done;
  logic [31:0] reqAddr;
  logic [7:0]  reqByteEn;
  logic [7:0]  reqElem;

  int total = 0;
  int bad = 0;
  int idxArr[16];

  always #10 clk = ~clk;

  vec_addr_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .modeSel(modeSel), .widthSel(widthSel), .stride(stride),
    .vecLen(vecLen), .maskEn(maskEn), .isStore(isStore),
    .isSigned(isSigned), .stall(stall), .maskBit(maskBit), .idxIn(idxIn),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqByteEn(reqByteEn),
    .reqElem(reqElem), .reqStore(reqStore), .reqSigned(reqSigned),
    .misalign(misalign), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  // Behavioural model: one element per unstalled cycle, compared every clock.
  // maskPat: 0 none, 1 every third element off. stallPat: stall when cyc%4==1.
  task automatic runVec(input string req, input logic [31:0] base,
                        input int mode, input int w, input int strideV,
                        input int len, input bit mEn, input int maskPat,
                        input bit stallPat, input bit st, input bit sg,
                        input bit poke);
    int e = 0;
    int cyc = 0;
    int size = 1 << w;
    @(negedge clk);
    baseAddr = base; modeSel = 2'(mode); widthSel = 2'(w);
    stride = 32'(strideV); vecLen = 9'(len); maskEn = mEn;
    isStore = st; isSigned = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (e < len) begin
      logic [31:0] expAddr;
      bit act, al, sv;
      int lanes;
      sv = stallPat && (cyc % 4 == 1);
      stall = sv;
      maskBit = (maskPat == 1) ? (e % 3 != 1) : 1'b1;
      idxIn = (e < 16) ? 32'(idxArr[e]) : 32'd0;
      start = poke && (cyc == 2);
      if (poke && cyc == 2) baseAddr = 32'hDEAD0000;
      #1;
      if (mode == 2)      expAddr = base + 32'(idxArr[e]);
      else if (mode == 1) expAddr = base + 32'(e * strideV);
      else                expAddr = base + 32'(e * size);
      act = !mEn || maskBit;
      al  = (expAddr % size) == 0;
      chk(req, "busy", busy, 1);
      chk(req, "done", done, 0);
      chk(req, "reqElem R13", reqElem, e);
      chk(req, "reqValid", reqValid, !sv && act && al);
      chk(req, "misalign R6", misalign, !sv && act && !al);
      if (!sv && act && al) begin
        lanes = ((1 << size) - 1) << (expAddr % 8);
        chk(req, "reqAddr", reqAddr, expAddr);
        chk(req, "byteEn R4", reqByteEn, lanes & 255);
        chk(req, "reqStore R10", reqStore, st);
        chk(req, "reqSigned R10", reqSigned, sg && !st);
      end
      if (!sv) e++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; stall = 1'b0; maskBit = 1'b1;
    #1;
    chk(req, "done R8", done, 1);
    chk(req, "noreq R8", reqValid, 0);
    chk(req, "busy R8", busy, 0);
    @(negedge clk);
    #1;
    chk(req, "done fall R8", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12", "busy", busy, 0);
    chk("R12", "done", done, 0);
    chk("R12", "reqValid", reqValid, 0);
    chk("R12", "misalign", misalign, 0);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) idxArr[i] = 0;
    // R1 sequential 32-bit load, signed
    runVec("R1", 32'h0000_1000, 0, 2, 0, 5, 0, 0, 0, 0, 1, 0);
    // R2 negative stride, 64-bit store, with stalls (R7)
    runVec("R2", 32'h0000_2000, 1, 3, -24, 4, 0, 0, 1, 1, 1, 0);
    // R6 stride 6 at 32-bit: alternate elements misaligned
    runVec("R6", 32'h0000_0100, 1, 2, 6, 5, 0, 0, 0, 0, 0, 0);
    // R3 gather 16-bit with negative and odd offsets, masking (R5)
    idxArr[0] = 8;  idxArr[1] = -2; idxArr[2] = 3;  idxArr[3] = -16;
    idxArr[4] = 14; idxArr[5] = 7;  idxArr[6] = 0;  idxArr[7] = -6;
    runVec("R3", 32'h0000_4000, 2, 1, 0, 8, 1, 1, 0, 0, 0, 0);
    // R9 zero length
    runVec("R9", 32'h0000_5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 start pulse during a run is ignored
    runVec("R11", 32'h0000_6000, 0, 1, 0, 6, 0, 0, 1, 1, 0, 1);
    // R13 full length 256 bytes, masked (R5) and stalled (R7)
    runVec("R13", 32'h0000_7003, 0, 0, 0, 256, 1, 1, 1, 0, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule